// File: doc/BRIEF.md
# Macro Write-Back and Method Dispatch Unit

This unit is the last stage of a small macro processor. Each accepted operation carries a 3-bit result mode, a destination register index and a 32-bit result that an earlier stage has already computed. The mode selects a fused action. The destination is written either with the result or with the next word taken from an input parameter buffer. The method address register may be loaded from the result. A value may be sent out on a method write port, which is either the result, a fetched parameter, or a 6-bit field of the result.

The unit holds an eight-entry register file. Entry 0 is fixed at zero. It also holds a read pointer into an external parameter buffer and a method address register that steps forward after every send. A start pulse opens a macro. It clears the registers, preloads register 1 with parameter 0 and sets the pointer to 1. A done pulse closes the macro and checks that every parameter was used.

Top module: `wb_dispatch`

## Requirements
- R1: After reset, `snd_valid`, `underflow_err` and `leftover_err` are 0, and every register reads as 0.
- R2: A `mac_start` pulse clears all registers, the method address and both error flags, loads register 1 with buffer entry 0, and latches `prm_count`. The next fetch then returns buffer entry 1.
- R3: Register 0 always reads as zero. A write to index 0 is discarded.
- R4: Mode 0 writes the next fetched parameter to the destination and discards the result. Mode 1 writes the result to the destination.
- R5: Mode 2 writes the result and loads it as method address. Mode 3 writes a fetched parameter and sends the result. Mode 4 writes the result and sends it.
- R6: Mode 5 writes a fetched parameter and loads the result as method address. Mode 6 writes the result, loads it as method address, and sends a fetched parameter.
- R7: Mode 7 writes the result, loads it as method address, and sends result bits [17:12] zero-extended.
- R8: The method address holds a 12-bit address in bits [11:0] and a 6-bit increment in bits [17:12]. A send drives `snd_valid` for one cycle, one clock after the operation. It carries the address in force after any load made by the same operation. After each send, the address advances by the increment, modulo 4096.
- R9: A fetch made when the pointer has reached the latched count returns zero and leaves the pointer unchanged. It also sets `underflow_err`, which stays set until the next start.
- R10: One cycle after `mac_done`, `leftover_err` is 1 if the pointer differs from the latched count, and 0 otherwise. It holds that value until the next start.
- R11: An operation presented in the same cycle as `mac_start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_start | input | 1 | Opens a macro |
| prm_count | input | 5 | Number of parameters in the buffer, sampled at start |
| prm_idx | output | 4 | Buffer read index |
| prm_data | input | 32 | Buffer word at `prm_idx` |
| op_valid | input | 1 | Operation present |
| op_mode | input | 3 | Result mode 0..7 |
| op_dst | input | 3 | Destination register index |
| op_result | input | 32 | Computed result |
| rd_sel_a | input | 3 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_sel_b | input | 3 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| mac_done | input | 1 | Closes a macro and runs the leftover check |
| snd_valid | output | 1 | Method write strobe |
| snd_addr | output | 12 | Method write address |
| snd_data | output | 32 | Method write data |
| underflow_err | output | 1 | Sticky fetch-past-end flag |
| leftover_err | output | 1 | Parameters left unused at done |

## Verification
Each of the eight modes is driven with results that have distinct values in the address, increment and field bit ranges. Because of this, a swapped send source, a missed address load or a wrong field slice each produce a different value in the scoreboard. The sequence places a mode that loads and sends in the same operation right after plain sends. This shows whether the send uses the freshly loaded address or the old one. One load puts the address near 4095 with a large increment, which exercises the wrap. A macro is also run that consumes its parameters exactly and then fetches once more. This separates the underflow case from the leftover case. A second start with an operation presented in the same cycle checks that start takes priority.

// File: rtl/wb_pkg.sv
package wb_pkg;

  localparam int DATA_W = 32;
  localparam int MA_AW  = 12;
  localparam int MA_IW  = 6;

  typedef enum logic [2:0] {
    WB_FETCH_ONLY   = 3'd0,
    WB_MOVE         = 3'd1,
    WB_MOVE_LOAD    = 3'd2,
    WB_FETCH_SEND   = 3'd3,
    WB_MOVE_SEND    = 3'd4,
    WB_FETCH_LOAD   = 3'd5,
    WB_MOVE_LOAD_PS = 3'd6,
    WB_MOVE_LOAD_FS = 3'd7
  } wb_mode_e;

  typedef enum logic [1:0] {
    SRC_RESULT = 2'd0,
    SRC_PARAM  = 2'd1,
    SRC_FIELD  = 2'd2
  } snd_src_e;

  typedef struct packed {
    logic     fetch;
    logic     reg_from_param;
    logic     load_ma;
    logic     send;
    snd_src_e snd_src;
  } wb_ctl_t;

  function automatic wb_ctl_t decode_mode(input logic [2:0] m);
    wb_ctl_t c;
    c = '{fetch: 1'b0, reg_from_param: 1'b0, load_ma: 1'b0, send: 1'b0, snd_src: SRC_RESULT};
    case (wb_mode_e'(m))
      WB_FETCH_ONLY:   begin c.fetch = 1'b1; c.reg_from_param = 1'b1; end
      WB_MOVE:         ;
      WB_MOVE_LOAD:    c.load_ma = 1'b1;
      WB_FETCH_SEND:   begin c.fetch = 1'b1; c.reg_from_param = 1'b1; c.send = 1'b1; end
      WB_MOVE_SEND:    c.send = 1'b1;
      WB_FETCH_LOAD:   begin c.fetch = 1'b1; c.reg_from_param = 1'b1; c.load_ma = 1'b1; end
      WB_MOVE_LOAD_PS: begin c.load_ma = 1'b1; c.fetch = 1'b1; c.send = 1'b1; c.snd_src = SRC_PARAM; end
      WB_MOVE_LOAD_FS: begin c.load_ma = 1'b1; c.send = 1'b1; c.snd_src = SRC_FIELD; end
      default:         ;
    endcase
    return c;
  endfunction

  // Increment field of a result, zero-extended to the data width.
  function automatic logic [DATA_W-1:0] inc_field(input logic [DATA_W-1:0] r);
    return {{(DATA_W-MA_IW){1'b0}}, r[MA_AW+MA_IW-1:MA_AW]};
  endfunction

  function automatic logic [MA_AW-1:0] ma_step(input logic [MA_AW-1:0] a,
                                               input logic [MA_IW-1:0] inc);
    return a + {{(MA_AW-MA_IW){1'b0}}, inc};
  endfunction

endpackage

// File: rtl/wb_regfile.sv
module wb_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] preload_data,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra_a,
  input  logic [RW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] store [NREG];
  logic          wr_hit;

  // entry 0 is never a write target, so it keeps its reset value of zero
  assign wr_hit = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
      store[1] <= preload_data;
    end else if (wr_hit) begin
      store[waddr] <= wdata;
    end
  end

  assign rd_a = store[ra_a];
  assign rd_b = store[ra_b];

  // R3
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == '0) |-> (rd_a == '0));

  // R2
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (store[1] == $past(preload_data)));

endmodule

// File: rtl/wb_param_feed.sv
module wb_param_feed #(
  parameter int DW     = 32,
  parameter int PIDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PIDX_W:0] cnt_in,
  input  logic            fetch,
  input  logic            done,
  output logic [PIDX_W-1:0] prm_idx,
  input  logic [DW-1:0]   prm_data,
  output logic [DW-1:0]   fetch_data,
  output logic            underflow_err,
  output logic            leftover_err
);

  localparam logic [PIDX_W:0] ONE = {{PIDX_W{1'b0}}, 1'b1};

  logic [PIDX_W:0] ptr_q;
  logic [PIDX_W:0] cnt_q;
  logic            exhausted;
  logic            fetch_miss;

  assign exhausted  = (ptr_q >= cnt_q);
  assign fetch_miss = fetch && exhausted;
  assign prm_idx    = start ? '0 : ptr_q[PIDX_W-1:0];
  assign fetch_data = exhausted ? '0 : prm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q         <= '0;
      cnt_q         <= '0;
      underflow_err <= 1'b0;
      leftover_err  <= 1'b0;
    end else if (start) begin
      ptr_q         <= ONE;
      cnt_q         <= cnt_in;
      underflow_err <= 1'b0;
      leftover_err  <= 1'b0;
    end else begin
      if (fetch && !exhausted) ptr_q <= ptr_q + ONE;
      if (fetch_miss)          underflow_err <= 1'b1;
      if (done)                leftover_err  <= (ptr_q != cnt_q);
    end
  end

  // R9
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_miss && !start) |=> underflow_err);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_miss && !start) |=> $stable(ptr_q));

  // R10
  leftover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (leftover_err == ($past(ptr_q) != $past(cnt_q))));

endmodule

// File: rtl/wb_method_port.sv
module wb_method_port #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          send,
  input  logic [DW-1:0] send_val,
  output logic          snd_valid,
  output logic [AW-1:0] snd_addr,
  output logic [DW-1:0] snd_data
);
  import wb_pkg::*;

  logic [AW-1:0] ma_addr_q;
  logic [IW-1:0] ma_inc_q;
  logic [AW-1:0] cur_addr;
  logic [IW-1:0] cur_inc;

  // an address loaded by the same operation is the one the send uses
  assign cur_addr = load ? load_val[AW-1:0]     : ma_addr_q;
  assign cur_inc  = load ? load_val[AW+IW-1:AW] : ma_inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_addr_q <= '0;
      ma_inc_q  <= '0;
      snd_valid <= 1'b0;
      snd_addr  <= '0;
      snd_data  <= '0;
    end else if (start) begin
      ma_addr_q <= '0;
      ma_inc_q  <= '0;
      snd_valid <= 1'b0;
    end else begin
      snd_valid <= send;
      ma_inc_q  <= cur_inc;
      if (send) begin
        snd_addr  <= cur_addr;
        snd_data  <= send_val;
        ma_addr_q <= ma_step(cur_addr, cur_inc);
      end else begin
        ma_addr_q <= cur_addr;
      end
    end
  end

  // R8
  send_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !start) |=> snd_valid);

  // R8
  step_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> (ma_addr_q == AW'(snd_addr + {{(AW-IW){1'b0}}, ma_inc_q})));

endmodule

// File: rtl/wb_dispatch.sv
module wb_dispatch #(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int PIDX_W = 4,
  parameter int MA_AW  = 12,
  parameter int MA_IW  = 6,
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_start,
  input  logic [PIDX_W:0]   prm_count,
  output logic [PIDX_W-1:0] prm_idx,
  input  logic [DW-1:0]     prm_data,
  input  logic              op_valid,
  input  logic [2:0]        op_mode,
  input  logic [RW-1:0]     op_dst,
  input  logic [DW-1:0]     op_result,
  input  logic [RW-1:0]     rd_sel_a,
  output logic [DW-1:0]     rd_data_a,
  input  logic [RW-1:0]     rd_sel_b,
  output logic [DW-1:0]     rd_data_b,
  input  logic              mac_done,
  output logic              snd_valid,
  output logic [MA_AW-1:0]  snd_addr,
  output logic [DW-1:0]     snd_data,
  output logic              underflow_err,
  output logic              leftover_err
);
  import wb_pkg::*;

  wb_ctl_t       ctl;
  logic          act;
  logic          do_fetch;
  logic          do_load;
  logic          do_send;
  logic [DW-1:0] fetch_data;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] send_val;

  assign ctl      = decode_mode(op_mode);
  assign act      = op_valid && !mac_start;
  assign do_fetch = act && ctl.fetch;
  assign do_load  = act && ctl.load_ma;
  assign do_send  = act && ctl.send;

  assign reg_wdata = ctl.reg_from_param ? fetch_data : op_result;

  always_comb begin
    case (ctl.snd_src)
      SRC_PARAM: send_val = fetch_data;
      SRC_FIELD: send_val = inc_field(op_result);
      default:   send_val = op_result;
    endcase
  end

  wb_param_feed #(.DW(DW), .PIDX_W(PIDX_W)) feed_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (mac_start),
    .cnt_in       (prm_count),
    .fetch        (do_fetch),
    .done         (mac_done),
    .prm_idx      (prm_idx),
    .prm_data     (prm_data),
    .fetch_data   (fetch_data),
    .underflow_err(underflow_err),
    .leftover_err (leftover_err)
  );

  wb_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (mac_start),
    .preload_data(prm_data),
    .we          (act),
    .waddr       (op_dst),
    .wdata       (reg_wdata),
    .ra_a        (rd_sel_a),
    .ra_b        (rd_sel_b),
    .rd_a        (rd_data_a),
    .rd_b        (rd_data_b)
  );

  wb_method_port #(.DW(DW), .AW(MA_AW), .IW(MA_IW)) mport_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mac_start),
    .load     (do_load),
    .load_val (op_result),
    .send     (do_send),
    .send_val (send_val),
    .snd_valid(snd_valid),
    .snd_addr (snd_addr),
    .snd_data (snd_data)
  );

  // R11
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> !snd_valid);

  // R2
  start_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> (!underflow_err && !leftover_err));

  // R7
  field_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op_mode == 3'd7) |=> (snd_data[DW-1:MA_IW] == '0));

endmodule

// File: tb/wb_dispatch_tb.sv
module wb_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_start = 1'b0;
  logic [4:0]  prm_count = '0;
  logic [3:0]  prm_idx;
  logic [31:0] prm_data;
  logic        op_valid = 1'b0;
  logic [2:0]  op_mode = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic [2:0]  rd_sel_a = '0;
  logic [31:0] rd_data_a;
  logic [2:0]  rd_sel_b = '0;
  logic [31:0] rd_data_b;
  logic        mac_done = 1'b0;
  logic        snd_valid;
  logic [11:0] snd_addr;
  logic [31:0] snd_data;
  logic        underflow_err;
  logic        leftover_err;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] pbuf [16];
  assign prm_data = pbuf[prm_idx];

  always #10 clk = ~clk;

  wb_dispatch dut_i (.*);

  // reference state
  logic [31:0] m_reg [8];
  int          m_ptr, m_cnt;
  logic [11:0] m_addr;
  logic [5:0]  m_inc;
  logic [43:0] exp_q [$];   // {addr, data}

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every send against the scoreboard
  always @(negedge clk) begin
    if (rst_n && snd_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected send", {20'd0, snd_addr}, 32'hFFFF_FFFF);
      end else begin
        logic [43:0] e;
        e = exp_q.pop_front();
        check("R8 send addr", {20'd0, snd_addr}, {20'd0, e[43:32]});
        check("R5/R6/R7 send data", snd_data, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] m_fetch();
    if (m_ptr >= m_cnt) return 32'd0;
    m_ptr++;
    return pbuf[m_ptr-1];
  endfunction

  task automatic m_send(input logic [31:0] v);
    exp_q.push_back({m_addr, v});
    m_addr = m_addr + {6'd0, m_inc};
  endtask

  task automatic m_load(input logic [31:0] r);
    m_addr = r[11:0];
    m_inc  = r[17:12];
  endtask

  task automatic m_op(input int mode, input int dst, input logic [31:0] r);
    logic [31:0] w;
    case (mode)
      0: w = m_fetch();
      1: w = r;
      2: begin w = r; m_load(r); end
      3: begin w = m_fetch(); m_send(r); end
      4: begin w = r; m_send(r); end
      5: begin w = m_fetch(); m_load(r); end
      6: begin w = r; m_load(r); m_send(m_fetch()); end
      default: begin w = r; m_load(r); m_send({26'd0, r[17:12]}); end
    endcase
    if (dst != 0) m_reg[dst] = w;
  endtask

  task automatic do_start(input int cnt);
    mac_start = 1'b1; prm_count = cnt[4:0];
    @(negedge clk);
    mac_start = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_reg[1] = pbuf[0]; m_ptr = 1; m_cnt = cnt; m_addr = '0; m_inc = '0;
  endtask

  task automatic do_op(input int mode, input int dst, input logic [31:0] r);
    m_op(mode, dst, r);
    op_valid = 1'b1; op_mode = mode[2:0]; op_dst = dst[2:0]; op_result = r;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_reg(input string req, input int idx);
    rd_sel_a = idx[2:0]; rd_sel_b = idx[2:0];
    #1;
    check(req, rd_data_a, m_reg[idx]);
    check(req, rd_data_b, m_reg[idx]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) pbuf[i] = 32'h1100_0000 + 32'h11 * (i + 1);
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 snd_valid", {31'd0, snd_valid}, 32'd0);
    check("R1 errors", {30'd0, underflow_err, leftover_err}, 32'd0);
    for (int i = 0; i < 8; i++) check_reg("R1 reg", i);

    // R2: preload and pointer
    do_start(6);
    check_reg("R2 r1 preload", 1);
    check_reg("R2 r2 cleared", 2);
    do_op(1, 2, 32'hDEAD_BEEF);  check_reg("R4 move", 2);
    do_op(1, 0, 32'h1234_5678);  check_reg("R3 r0 write dropped", 0);
    do_op(0, 3, 32'hFFFF_0000);  check_reg("R4 fetch entry 1", 3);
    do_op(2, 4, 32'h0000_2100);  check_reg("R5 move+load", 4);
    do_op(4, 5, 32'h0000_0ABC);  check_reg("R5 move+send", 5);
    do_op(3, 6, 32'h0000_0777);  check_reg("R5 fetch+send", 6);
    do_op(5, 7, 32'h0000_1FFF);  check_reg("R6 fetch+load", 7);
    do_op(6, 1, 32'h0003_FFFF);  check_reg("R6 load+param send wrap", 1);
    do_op(7, 2, 32'h0005_A123);  check_reg("R7 field send", 2);
    do_op(4, 3, 32'h0000_0042);  check_reg("R8 stepped addr", 3);
    do_op(0, 4, 32'h0);          check_reg("R4 last param", 4);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    check("R10 all consumed", {31'd0, leftover_err}, 32'd0);
    check("R9 no underflow yet", {31'd0, underflow_err}, 32'd0);
    do_op(0, 4, 32'h0);          check_reg("R9 zero on underflow", 4);
    check("R9 underflow flag", {31'd0, underflow_err}, 32'd1);
    do_op(0, 5, 32'h0);          check_reg("R9 pointer held", 5);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    check("R10 held pointer equals count", {31'd0, leftover_err}, 32'd0);

    // second macro: leftover and start priority
    for (int i = 0; i < 16; i++) pbuf[i] = 32'hA000_0000 + i;
    mac_start = 1'b1; prm_count = 5'd3;
    op_valid = 1'b1; op_mode = 3'd4; op_dst = 3'd2; op_result = 32'h5555;
    @(negedge clk);
    mac_start = 1'b0; op_valid = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_reg[1] = pbuf[0]; m_ptr = 1; m_cnt = 3; m_addr = '0; m_inc = '0;
    check_reg("R11 op ignored at start", 2);
    check("R2 underflow cleared", {31'd0, underflow_err}, 32'd0);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    check("R10 leftover", {31'd0, leftover_err}, 32'd1);
    do_op(4, 0, 32'h0000_0099);  // address restarts at 0 (R2)
    repeat (2) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule